// File: doc/BRIEF.md
# Accumulator ALU with Flag Register

This block is the arithmetic and bit-manipulation unit for an 8-bit accumulator machine. The control logic supplies an operation code, the accumulator, a second operand, an immediate mask byte and the incoming carry. The block returns a result byte on every cycle from combinational logic. For a multiply it also returns a second, upper result byte, intended for the auxiliary B register. The unit covers subtract-with-borrow, an unsigned 8x8 multiply, four rotates, a nibble swap, and masked set/complement of bits in a destination byte.

Three status flags sit in a small register: carry, auxiliary carry and overflow. This register loads on a rising clock edge only when the flag write strobe is high. Each operation writes only the flags it defines and leaves the others as they were. The registered carry is available at the outputs, so the control logic can feed it back as the next incoming carry. Reset is asserted asynchronously and released in step with the clock.

Top module: `acc_alu`

## Requirements
- R1: Subtract (op 0) gives res_o = (acc_i - opnd_i - cy_i) mod 256. On a flag write, carry is set exactly when that difference needs a borrow out of bit 7.
- R2: On a subtract flag write, auxiliary carry is set exactly when the low nibbles need a borrow, that is when acc_i[3:0] < opnd_i[3:0] + cy_i.
- R3: On a subtract flag write, overflow is set exactly when the borrow out of bit 6 differs from the borrow out of bit 7.
- R4: Multiply (op 1) gives res_o = low byte and res_hi_o = high byte of acc_i*breg_i. res_hi_vld_o is high for op 1 and for no other code.
- R5: On a multiply flag write, overflow is set exactly when the product exceeds 255 and carry is cleared. Auxiliary carry keeps its value.
- R6: Rotate left through carry (op 4) gives {acc_i[6:0], cy_i} and takes carry from acc_i[7]. Rotate right through carry (op 5) gives {cy_i, acc_i[7:1]} and takes carry from acc_i[0]. Neither changes auxiliary carry or overflow.
- R7: Plain rotate left (op 2) gives {acc_i[6:0], acc_i[7]} and plain rotate right (op 3) gives {acc_i[0], acc_i[7:1]}. Neither changes any flag.
- R8: Swap (op 6) gives {acc_i[3:0], acc_i[7:4]} and changes no flag.
- R9: Masked set (op 7) gives opnd_i | m and masked complement (op 8) gives opnd_i ^ m. The mask m is acc_i when mask_acc_i is 1 and imm_i when it is 0. Neither changes any flag.
- R10: The flags change only at a rising clock edge on which flag_we_i is high. With flag_we_i low they keep their values whatever the operation.
- R11: Reset clears all three flags. Codes 9 to 15 give res_o = acc_i and change no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 4 | Operation code |
| acc_i | input | 8 | Accumulator operand |
| opnd_i | input | 8 | Second operand / destination byte of masked ops |
| imm_i | input | 8 | Immediate mask byte |
| mask_acc_i | input | 1 | 1: mask from accumulator, 0: from immediate |
| breg_i | input | 8 | B register, multiplier |
| cy_i | input | 1 | Incoming carry |
| flag_we_i | input | 1 | Flag register write strobe |
| res_o | output | 8 | Result byte |
| res_hi_o | output | 8 | Upper product byte |
| res_hi_vld_o | output | 1 | Upper byte meaningful (multiply) |
| cy_o | output | 1 | Registered carry |
| ac_o | output | 1 | Registered auxiliary carry |
| ov_o | output | 1 | Registered overflow |

## Verification
The hardest cases to reach are the subtract overflow cases. In these, a borrow propagates out of bit 6 and does not propagate out of bit 7, or the reverse. Both depend on the incoming carry tipping an otherwise equal operand pair. The stimulus covers every accumulator value against a dense stride of subtrahends, each with carry 0 and carry 1. The flag write strobe is dropped on a fixed cadence, so that the bench also sees flags held across defined operations.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  typedef enum logic [3:0] {
    OP_SUB  = 4'd0,
    OP_MUL  = 4'd1,
    OP_ROL  = 4'd2,
    OP_ROR  = 4'd3,
    OP_ROLC = 4'd4,
    OP_RORC = 4'd5,
    OP_SWAP = 4'd6,
    OP_MSET = 4'd7,
    OP_MCPL = 4'd8
  } alu_op_t;

  typedef struct packed {
    logic cy;
    logic ac;
    logic ov;
  } flags_t;
endpackage

// File: rtl/acc_alu_arith.sv
module acc_alu_arith
  #(parameter int W = 8)
  (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] mb,
    input  logic         cin,
    output logic [W-1:0] diff,
    output logic         bor_top,
    output logic         bor_half,
    output logic         sub_ov,
    output logic [W-1:0] prod_lo,
    output logic [W-1:0] prod_hi
  );
  localparam int HALF = W / 2;

  logic [W:0]      full_d;
  logic [HALF:0]   low_d;
  logic [W-1:0]    part_d;
  logic [2*W-1:0]  prod;

  always_comb begin
    full_d = {1'b0, a} - {1'b0, b} - {{W{1'b0}}, cin};
    low_d  = {1'b0, a[HALF-1:0]} - {1'b0, b[HALF-1:0]} - {{HALF{1'b0}}, cin};
    part_d = {1'b0, a[W-2:0]} - {1'b0, b[W-2:0]} - {{(W-1){1'b0}}, cin};
    prod   = {{W{1'b0}}, a} * {{W{1'b0}}, mb};
  end

  assign diff     = full_d[W-1:0];
  assign bor_top  = full_d[W];
  assign bor_half = low_d[HALF];
  assign sub_ov   = part_d[W-1] ^ full_d[W];
  assign prod_lo  = prod[W-1:0];
  assign prod_hi  = prod[2*W-1:W];

  always_comb begin
    if (b == '0 && !cin)
      assert (!bor_top && !bor_half && !sub_ov) else $error("AST_NO_BORROW_ZERO");  // R1
  end
endmodule

// File: rtl/acc_alu_shift.sv
module acc_alu_shift
  import acc_alu_pkg::*;
  #(parameter int W = 8)
  (
    input  alu_op_t      op,
    input  logic [W-1:0] a,
    input  logic         cin,
    output logic [W-1:0] res,
    output logic         cout
  );
  localparam int HALF = W / 2;

  always_comb begin
    res  = a;
    cout = cin;
    unique case (op)
      OP_ROL:  res = {a[W-2:0], a[W-1]};
      OP_ROR:  res = {a[0], a[W-1:1]};
      OP_ROLC: begin res = {a[W-2:0], cin}; cout = a[W-1]; end
      OP_RORC: begin res = {cin, a[W-1:1]}; cout = a[0]; end
      OP_SWAP: res = {a[HALF-1:0], a[W-1:HALF]};
      default: ;
    endcase
  end
endmodule

// File: rtl/acc_alu_logic.sv
module acc_alu_logic
  #(parameter int W = 8)
  (
    input  logic [W-1:0] dest,
    input  logic [W-1:0] mask,
    input  logic         toggle,
    output logic [W-1:0] res
  );
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_comb begin
      if (!mask[i])    res[i] = dest[i];
      else if (toggle) res[i] = ~dest[i];
      else             res[i] = 1'b1;
    end
  end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
  #(parameter int W = 8)
  (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [3:0]   op_i,
    input  logic [W-1:0] acc_i,
    input  logic [W-1:0] opnd_i,
    input  logic [W-1:0] imm_i,
    input  logic         mask_acc_i,
    input  logic [W-1:0] breg_i,
    input  logic         cy_i,
    input  logic         flag_we_i,
    output logic [W-1:0] res_o,
    output logic [W-1:0] res_hi_o,
    output logic         res_hi_vld_o,
    output logic         cy_o,
    output logic         ac_o,
    output logic         ov_o
  );
  alu_op_t op;
  assign op = alu_op_t'(op_i);

  // reset: asynchronous assertion, clocked release
  logic rst_s1, rst_s2;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s2 <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s2 <= rst_s1;
    end
  end

  logic [W-1:0] diff, plo, phi, sh_res, lg_res, mask;
  logic         bor_top, bor_half, sub_ov, sh_cy;

  acc_alu_arith #(.W(W)) u_arith (
    .a(acc_i), .b(opnd_i), .mb(breg_i), .cin(cy_i),
    .diff(diff), .bor_top(bor_top), .bor_half(bor_half), .sub_ov(sub_ov),
    .prod_lo(plo), .prod_hi(phi)
  );

  acc_alu_shift #(.W(W)) u_shift (
    .op(op), .a(acc_i), .cin(cy_i), .res(sh_res), .cout(sh_cy)
  );

  assign mask = mask_acc_i ? acc_i : imm_i;

  acc_alu_logic #(.W(W)) u_logic (
    .dest(opnd_i), .mask(mask), .toggle(op == OP_MCPL), .res(lg_res)
  );

  flags_t flg_q, flg_d, flg_new;
  logic   wr_cy, wr_ac, wr_ov;

  // result mux and per-operation flag definitions
  always_comb begin
    res_o        = acc_i;
    res_hi_o     = '0;
    res_hi_vld_o = 1'b0;
    flg_new      = flg_q;
    wr_cy        = 1'b0;
    wr_ac        = 1'b0;
    wr_ov        = 1'b0;
    unique case (op)
      OP_SUB: begin
        res_o   = diff;
        flg_new = '{cy: bor_top, ac: bor_half, ov: sub_ov};
        wr_cy = 1'b1; wr_ac = 1'b1; wr_ov = 1'b1;
      end
      OP_MUL: begin
        res_o        = plo;
        res_hi_o     = phi;
        res_hi_vld_o = 1'b1;
        flg_new.cy   = 1'b0;
        flg_new.ov   = |phi;
        wr_cy = 1'b1; wr_ov = 1'b1;
      end
      OP_ROL, OP_ROR, OP_SWAP: res_o = sh_res;
      OP_ROLC, OP_RORC: begin
        res_o      = sh_res;
        flg_new.cy = sh_cy;
        wr_cy      = 1'b1;
      end
      OP_MSET, OP_MCPL: res_o = lg_res;
      default: ;
    endcase
  end

  // flag next state
  always_comb begin
    flg_d = flg_q;
    if (flag_we_i) begin
      if (wr_cy) flg_d.cy = flg_new.cy;
      if (wr_ac) flg_d.ac = flg_new.ac;
      if (wr_ov) flg_d.ov = flg_new.ov;
    end
  end

  always_ff @(posedge clk or negedge rst_s2) begin
    if (!rst_s2) flg_q <= '0;
    else         flg_q <= flg_d;
  end

  assign cy_o = flg_q.cy;
  assign ac_o = flg_q.ac;
  assign ov_o = flg_q.ov;

  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_s2)
    !flag_we_i |=> $stable({cy_o, ac_o, ov_o}))
    else $error("AST_FLAGS_HOLD");  // R10
  AST_MUL_CY_CLEAR: assert property (@(posedge clk) disable iff (!rst_s2)
    (flag_we_i && op_i == 4'd1) |=> (!cy_o && $stable(ac_o)))
    else $error("AST_MUL_CY_CLEAR");  // R5
  AST_MUL_OV: assert property (@(posedge clk) disable iff (!rst_s2)
    (flag_we_i && op_i == 4'd1) |=> (ov_o == ($past(res_hi_o) != '0)))
    else $error("AST_MUL_OV");  // R5
  AST_RLC_CY: assert property (@(posedge clk) disable iff (!rst_s2)
    (flag_we_i && op_i == 4'd4) |=> (cy_o == $past(acc_i[W-1])))
    else $error("AST_RLC_CY");  // R6
  AST_SWAP_NOFLAG: assert property (@(posedge clk) disable iff (!rst_s2)
    (op_i == 4'd6) |=> $stable({cy_o, ac_o, ov_o}))
    else $error("AST_SWAP_NOFLAG");  // R8
  AST_HI_VLD: assert property (@(posedge clk) disable iff (!rst_s2)
    res_hi_vld_o |-> (op_i == 4'd1))
    else $error("AST_HI_VLD");  // R4
endmodule

// File: tb/sim_acc_alu.sv
module sim_acc_alu;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] op_i = '0;
  logic [7:0] acc_i = '0, opnd_i = '0, imm_i = '0, breg_i = '0;
  logic       mask_acc_i = 1'b0, cy_i = 1'b0, flag_we_i = 1'b0;
  logic [7:0] res_o, res_hi_o;
  logic       res_hi_vld_o, cy_o, ac_o, ov_o;

  int checks = 0;
  int errors = 0;
  int n_drv  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  acc_alu u0 (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .acc_i(acc_i), .opnd_i(opnd_i),
    .imm_i(imm_i), .mask_acc_i(mask_acc_i), .breg_i(breg_i), .cy_i(cy_i),
    .flag_we_i(flag_we_i), .res_o(res_o), .res_hi_o(res_hi_o),
    .res_hi_vld_o(res_hi_vld_o), .cy_o(cy_o), .ac_o(ac_o), .ov_o(ov_o)
  );

  typedef struct {
    logic [7:0] res, hi;
    logic       hv, cy, ac, ov;
    string      tag;
  } exp_t;

  exp_t q[$];
  logic m_cy = 1'b0, m_ac = 1'b0, m_ov = 1'b0;  // reference flag register

  task automatic chk(input string tag, input int act, input int exp_v);
    checks++;
    if (act != exp_v) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp_v);
    end
  endtask

  // driver: applies one operation at the falling edge and queues the expectation
  task automatic drive(input int op, input int a, input int b, input int im,
                       input bit msel, input int bb, input bit ci, input bit we);
    exp_t e;
    int   r, t, lo, p;
    @(negedge clk);
    op_i = op[3:0]; acc_i = a[7:0]; opnd_i = b[7:0]; imm_i = im[7:0];
    mask_acc_i = msel; breg_i = bb[7:0]; cy_i = ci; flag_we_i = we;
    e.hi = 8'h00; e.hv = 1'b0; r = a;
    case (op)
      0: begin
        t = a - b - ci; lo = (a % 16) - (b % 16) - ci; p = (a % 128) - (b % 128) - ci;
        r = t & 255;
        e.tag = "R1/R2/R3";
        if (we) begin m_cy = (t < 0); m_ac = (lo < 0); m_ov = ((p < 0) != (t < 0)); end
      end
      1: begin
        p = a * bb; r = p & 255; e.hi = p[15:8]; e.hv = 1'b1; e.tag = "R4/R5";
        if (we) begin m_cy = 1'b0; m_ov = (p > 255); end
      end
      2: begin r = ((a << 1) | (a >> 7)) & 255; e.tag = "R7"; end
      3: begin r = ((a >> 1) | (a << 7)) & 255; e.tag = "R7"; end
      4: begin r = ((a << 1) | ci) & 255; e.tag = "R6"; if (we) m_cy = a[7]; end
      5: begin r = (a >> 1) | (ci << 7); e.tag = "R6"; if (we) m_cy = a[0]; end
      6: begin r = ((a << 4) | (a >> 4)) & 255; e.tag = "R8"; end
      7: begin r = b | (msel ? a : im); e.tag = "R9"; end
      8: begin r = b ^ (msel ? a : im); e.tag = "R9"; end
      default: begin r = a; e.tag = "R11"; end
    endcase
    if (!we) e.tag = {e.tag, "/R10"};
    e.res = r[7:0]; e.cy = m_cy; e.ac = m_ac; e.ov = m_ov;
    q.push_back(e);
    n_drv++;
  endtask

  // monitor: result and flags are stable just after the rising edge
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk({e.tag, " res"}, res_o, e.res);
      chk({e.tag, " res_hi"}, res_hi_o, e.hi);
      chk({e.tag, " hi_vld"}, res_hi_vld_o, e.hv);
      chk({e.tag, " cy"}, cy_o, e.cy);
      chk({e.tag, " ac"}, ac_o, e.ac);
      chk({e.tag, " ov"}, ov_o, e.ov);
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R11 reset cy", cy_o, 0);
    chk("R11 reset ac", ac_o, 0);
    chk("R11 reset ov", ov_o, 0);
    // targeted subtract corner cases
    drive(0, 8'h80, 8'h01, 0, 0, 0, 0, 1);  // overflow, no borrow
    drive(0, 8'h00, 8'h00, 0, 0, 0, 1, 1);  // borrow from carry alone
    drive(0, 8'h7F, 8'hFF, 0, 0, 0, 0, 1);
    drive(0, 8'h10, 8'h01, 0, 0, 0, 0, 1);  // nibble borrow only
    drive(1, 8'hFF, 0, 0, 0, 8'hFF, 1, 1);  // largest product
    drive(1, 8'h0F, 0, 0, 0, 8'h11, 1, 1);  // fits in a byte
    for (int k = 9; k < 16; k++) drive(k, 8'h5A, 8'h33, 0, 0, 0, 1, 1);
    // subtract sweep
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b += 3)
        for (int c = 0; c < 2; c++)
          drive(0, a, b, 0, 0, 0, c[0], ((n_drv % 7) != 3));
    // multiply sweep
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b += 7)
        drive(1, a, 0, 0, 0, b, a[0], ((n_drv % 5) != 2));
    // rotates and swap
    for (int op = 2; op < 7; op++)
      for (int a = 0; a < 256; a++)
        for (int c = 0; c < 2; c++)
          drive(op, a, 0, 0, 0, 0, c[0], ((n_drv % 4) != 1));
    // masked set / complement, mask from either source
    for (int op = 7; op < 9; op++)
      for (int a = 0; a < 256; a += 5)
        for (int b = 0; b < 256; b += 13)
          for (int s = 0; s < 2; s++)
            drive(op, a, b, (a * 3 + 17) & 255, s[0], 0, 1'b1, 1'b1);
    @(negedge clk);
    flag_we_i = 1'b0;
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule